// File: doc/BRIEF.md
# AES3 Subframe Transmitter with Pin-Configured Channel Status

This block turns a stream of stereo audio words into AES3 / S/PDIF subframes and drives them out as a biphase-mark coded complementary line pair. A word-rate clock marks each new subframe: every change of its level loads one 24-bit sample together with that subframe's validity, user and channel-status bits. The block then sends the 32 time slots of the subframe over 64 master-clock cycles, one half-cell per cycle. It adds the synchronising preamble, the even-parity bit and the line coding.

Channel status comes from one of two sources, chosen by a pin. In static mode, a few control pins (copy, origin, emphasis, non-audio) build a consumer-format status block, and the block indexes it by its own 192-frame counter. In serial mode, the copy pin carries the C bit directly and is sampled once per subframe. A block-start strobe works in one of two directions. As an output it marks the subframe that opens each status block. As an input, a long enough pulse forces the next left subframe to open a new block.

Top module: `aes3_hw_tx`

## Requirements
- R1: While rst_n is low at a clock edge, tx_p, tx_n and blk_start_out are all low after that edge, and all frame, block and strobe state is cleared.
- R2: While transmitting, tx_n is the complement of tx_p. In every data slot (slots 4 to 31) the level changes at the start of the cell, and changes again mid-cell exactly when the slot bit is 1.
- R3: A change of lrck seen at clock edge E starts a subframe (lrck high = left, low = right). The first half-cell of slot 0 appears after edge E+1 and each half-cell lasts one clock. Slots 4 to 27 carry audio_in LSB first, slot 28 carries V, slot 29 carries U, slot 30 carries C, and slot 31 carries a parity bit that makes slots 4 to 31 hold an even number of ones.
- R4: Slots 0 to 3 carry a preamble. Written as eight half-cells in send order, relative to the line level before it, it is 11101000 for a left subframe that opens a block, 11100010 for other left subframes and 11100100 for right subframes. A preceding high level inverts the whole pattern.
- R5: v_in and u_in are captured at every lrck change, so each subframe carries its own validity and user bit.
- R6: Left subframes are counted modulo 192. The frame with index 0 opens a block, so without forcing, every 192nd left subframe uses the block-opening preamble.
- R7: With blk_dir_out high, blk_start_out is high from the edge that loads a block-opening left subframe until the next lrck change, and low otherwise. With blk_dir_out low, blk_start_out stays low.
- R8: With blk_dir_out low, holding blk_sync_in high for at least 3 consecutive clocks makes the next left subframe open a block and restarts the frame count at 0. A 2-clock pulse has no effect.
- R9: With cs_mode_b low, the C bit of both subframes of frame index i is taken from a consumer-format status block. Bit 0 (professional) is 0, bit 1 is nonaudio, bit 2 is c_copy (low = copyright asserted), bit 15 (category L) is orig, and all other bits are 0.
- R10: With cs_mode_b high, the C slot of each subframe carries c_copy as captured at that subframe's lrck change.
- R11: In static mode, emph_n low sets status bits 3, 4 and 5 to 1, 0, 0 (50/15 us pre-emphasis), and emph_n high sets them to 0, 0, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one half-cell per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| lrck | input | 1 | Word-rate clock; each change starts a subframe, high = left |
| audio_in | input | 24 | Sample captured at each lrck change |
| v_in | input | 1 | Validity bit for the subframe being started |
| u_in | input | 1 | User bit for the subframe being started |
| c_copy | input | 1 | Copy control (static mode) or serial C bit (serial mode) |
| cs_mode_b | input | 1 | 0 = status built from pins, 1 = serial C bit on c_copy |
| emph_n | input | 1 | Static mode: low = 50/15 us pre-emphasis |
| nonaudio | input | 1 | Static mode: value of status bit 1 |
| orig | input | 1 | Static mode: value of category L bit (bit 15) |
| blk_dir_out | input | 1 | 1 = block strobe is an output, 0 = block strobe is an input |
| blk_sync_in | input | 1 | Block-start force request (input direction) |
| blk_start_out | output | 1 | Block-start indication (output direction) |
| tx_p | output | 1 | Biphase-mark line, true side |
| tx_n | output | 1 | Biphase-mark line, complement side |

## Verification
The bench decodes the line itself, so a wrong half-cell counter or a misplaced load shifts every following slot. It shows up as bad cell-start transitions and a wrong preamble in the very next subframe. A frame counter that is off by one, or a forcing latch that stays set, appears only as a block-opening preamble in the wrong frame, and in static mode also as wrong C bits. That can take up to 192 frames to surface, which is why a full two-block run is decoded. A parity or slot-order error corrupts one subframe at once, and it is seen within its 64 clocks.

// File: rtl/aes3_tx_pkg.sv
// Package: shared definitions for the AES3 subframe transmitter.
// Assumes a fixed 32-slot subframe with two half-cells per slot.
package aes3_tx_pkg;
    localparam int SLOT_CNT  = 32;
    localparam int HALF_CNT  = 2 * SLOT_CNT;
    localparam int PRE_HALFS = 8;

    typedef enum logic [1:0] {
        PRE_LEFT  = 2'd0,
        PRE_RIGHT = 2'd1,
        PRE_BLOCK = 2'd2
    } preamble_e;

    // Half-cell pattern of a preamble, MSB sent first, relative to a low start level.
    function automatic logic [7:0] preamble_bits(preamble_e kind);
        case (kind)
            PRE_BLOCK: return 8'b1110_1000;
            PRE_RIGHT: return 8'b1110_0100;
            default:   return 8'b1110_0010;
        endcase
    endfunction
endpackage

// File: rtl/aes3_cs_bits.sv
// Module: channel-status bit source.
// In static mode it returns bit IDX of a consumer status block built from the
// control pins; in serial mode it passes the serial C pin through.
// Assumes idx is the frame index of the subframe being loaded.
module aes3_cs_bits #(
    parameter int IDX_W = 8
) (
    input  logic             mode_b,
    input  logic             c_pin,
    input  logic             emph_n,
    input  logic             nonaudio,
    input  logic             orig,
    input  logic [IDX_W-1:0] idx,
    output logic             c_bit
);
    // Select the status bit for the current frame index.
    always_comb begin
        if (mode_b) begin
            c_bit = c_pin;
        end else begin
            case (idx)
                IDX_W'(1):  c_bit = nonaudio;
                IDX_W'(2):  c_bit = c_pin;
                IDX_W'(3):  c_bit = ~emph_n;
                IDX_W'(15): c_bit = orig;
                default:    c_bit = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/aes3_blk_ctl.sv
// Module: channel-status block sequencer.
// Counts left subframes modulo BLK_FRAMES, applies a forced block restart after
// a strobe held for SYNC_HOLD clocks, and drives the block-start strobe output.
// Assumes load pulses for one clock per subframe, with is_left valid alongside.
module aes3_blk_ctl #(
    parameter int BLK_FRAMES = 192,
    parameter int SYNC_HOLD  = 3,
    localparam int IDX_W = $clog2(BLK_FRAMES),
    localparam int HW    = $clog2(SYNC_HOLD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             is_left,
    input  logic             dir_out,
    input  logic             sync_in,
    output logic [IDX_W-1:0] load_idx,
    output logic             opens_block,
    output logic             strobe_out
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(BLK_FRAMES - 1);

    logic [IDX_W-1:0] next_q, cur_q, start_idx;
    logic [HW-1:0]    hold_q;
    logic             pend_q, first_q, arm;

    // Index a left subframe would take, and index of the subframe being loaded.
    always_comb begin
        start_idx   = pend_q ? '0 : next_q;
        load_idx    = is_left ? start_idx : cur_q;
        opens_block = is_left && (start_idx == '0);
        arm         = !dir_out && sync_in && (hold_q == HW'(SYNC_HOLD - 1));
    end

    // Frame counter: advance on every left load, wrap at the block length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q <= '0;
            cur_q  <= '0;
        end else if (load && is_left) begin
            cur_q  <= start_idx;
            next_q <= (start_idx == LAST) ? '0 : start_idx + 1'b1;
        end
    end

    // Count consecutive high cycles of the force strobe, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (!dir_out && sync_in)
            hold_q <= (hold_q == HW'(SYNC_HOLD)) ? hold_q : hold_q + 1'b1;
        else
            hold_q <= '0;
    end

    // Latch a force request until the next left subframe consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (arm)
            pend_q <= 1'b1;
        else if (load && is_left)
            pend_q <= 1'b0;
    end

    // Remember whether the subframe on the line opened a block.
    always_ff @(posedge clk) begin
        if (!rst_n)
            first_q <= 1'b0;
        else if (load)
            first_q <= opens_block;
    end

    assign strobe_out = first_q & dir_out;

    // R6
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q < IDX_W'(BLK_FRAMES));

    // R8
    force_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && load && is_left && !arm) |=> (cur_q == '0 && !pend_q));
endmodule

// File: rtl/aes3_bmc_tx.sv
// Module: subframe register and biphase-mark line encoder.
// On load it captures a subframe; then it emits one half-cell per clock,
// preamble first, continuing from the current line level.
// Assumes loads arrive every 64 clocks; a missing load repeats the subframe.
module aes3_bmc_tx
    import aes3_tx_pkg::*;
#(
    parameter int AUD_W = 24,
    localparam int CW   = $clog2(HALF_CNT),
    localparam int SW   = $clog2(SLOT_CNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             is_left,
    input  logic             opens_block,
    input  logic [AUD_W-1:0] aud,
    input  logic             v_bit,
    input  logic             u_bit,
    input  logic             c_bit,
    output logic             line,
    output logic             active
);
    logic [SLOT_CNT-1:0] frame_q;
    preamble_e           pre_q;
    logic [CW-1:0]       cnt_q;
    logic                line_q, inv_q, active_q, nxt;
    logic [7:0]          pat;
    logic [SW-1:0]       slot;
    logic                par;

    // Even parity over audio, V, U and C.
    always_comb par = ^{c_bit, u_bit, v_bit, aud};

    // Next half-cell level from the position within the subframe.
    always_comb begin
        pat  = preamble_bits(pre_q);
        slot = cnt_q[CW-1:1];
        if (cnt_q < CW'(PRE_HALFS))
            nxt = pat[3'd7 - cnt_q[2:0]] ^ ((cnt_q == '0) ? line_q : inv_q);
        else if (!cnt_q[0])
            nxt = ~line_q;
        else
            nxt = frame_q[slot] ? ~line_q : line_q;
    end

    // Shift out half-cells and reload the subframe on each word-clock change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q  <= '0;
            pre_q    <= PRE_LEFT;
            cnt_q    <= '0;
            line_q   <= 1'b0;
            inv_q    <= 1'b0;
            active_q <= 1'b0;
        end else begin
            if (active_q) begin
                line_q <= nxt;
                cnt_q  <= cnt_q + 1'b1;
                if (cnt_q == '0)
                    inv_q <= line_q;
            end
            if (load) begin
                frame_q  <= {par, c_bit, u_bit, v_bit, aud, 4'b0000};
                pre_q    <= is_left ? (opens_block ? PRE_BLOCK : PRE_LEFT) : PRE_RIGHT;
                cnt_q    <= '0;
                active_q <= 1'b1;
            end
        end
    end

    assign line   = line_q;
    assign active = active_q;

    // R1
    rst_low_chk: assert property (@(posedge clk)
        !rst_n |=> (!line_q && !active_q));

    // R2
    cell_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && cnt_q >= CW'(PRE_HALFS) && !cnt_q[0]) |=> (line_q != $past(line_q)));

    // R4
    pre_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && cnt_q == '0) |=> (line_q != $past(line_q)));

    // R4
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && cnt_q == CW'(1)) |=> $stable(line_q));
endmodule

// File: rtl/aes3_hw_tx.sv
// Module: AES3 subframe transmitter, top level.
// Detects word-clock changes, sequences status blocks, selects the C bit and
// drives the complementary biphase-mark line pair.
// Assumes lrck is synchronous to clk and changes every 64 clocks.
module aes3_hw_tx #(
    parameter int AUD_W      = 24,
    parameter int BLK_FRAMES = 192,
    parameter int SYNC_HOLD  = 3,
    localparam int IDX_W = $clog2(BLK_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lrck,
    input  logic [AUD_W-1:0] audio_in,
    input  logic             v_in,
    input  logic             u_in,
    input  logic             c_copy,
    input  logic             cs_mode_b,
    input  logic             emph_n,
    input  logic             nonaudio,
    input  logic             orig,
    input  logic             blk_dir_out,
    input  logic             blk_sync_in,
    output logic             blk_start_out,
    output logic             tx_p,
    output logic             tx_n
);
    logic             lr_q, load, opens_block, c_bit, line, active;
    logic [IDX_W-1:0] load_idx;

    // Previous word-clock level for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lr_q <= 1'b0;
        else
            lr_q <= lrck;
    end

    assign load = lrck ^ lr_q;

    aes3_blk_ctl #(.BLK_FRAMES(BLK_FRAMES), .SYNC_HOLD(SYNC_HOLD)) u_blk (
        .clk(clk), .rst_n(rst_n), .load(load), .is_left(lrck),
        .dir_out(blk_dir_out), .sync_in(blk_sync_in),
        .load_idx(load_idx), .opens_block(opens_block), .strobe_out(blk_start_out)
    );

    aes3_cs_bits #(.IDX_W(IDX_W)) u_cs (
        .mode_b(cs_mode_b), .c_pin(c_copy), .emph_n(emph_n),
        .nonaudio(nonaudio), .orig(orig), .idx(load_idx), .c_bit(c_bit)
    );

    aes3_bmc_tx #(.AUD_W(AUD_W)) u_enc (
        .clk(clk), .rst_n(rst_n), .load(load), .is_left(lrck),
        .opens_block(opens_block), .aud(audio_in), .v_bit(v_in), .u_bit(u_in),
        .c_bit(c_bit), .line(line), .active(active)
    );

    assign tx_p = active & line;
    assign tx_n = active & ~line;
endmodule

// File: tb/aes3_hw_tx_test.sv
module aes3_hw_tx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lrck = 1'b0;
    logic [23:0] audio_in = '0;
    logic        v_in = 0, u_in = 0, c_copy = 0, cs_mode_b = 0;
    logic        emph_n = 1, nonaudio = 0, orig = 0;
    logic        blk_dir_out = 1, blk_sync_in = 0;
    logic        blk_start_out, tx_p, tx_n;

    int total = 0;
    int bad = 0;
    int ncap = 0;
    int force_len = 0;
    bit compl_err = 0;
    bit cap [0:50000];
    bit sob [0:50000];

    always #10 clk = ~clk;

    aes3_hw_tx uut (
        .clk(clk), .rst_n(rst_n), .lrck(lrck), .audio_in(audio_in),
        .v_in(v_in), .u_in(u_in), .c_copy(c_copy), .cs_mode_b(cs_mode_b),
        .emph_n(emph_n), .nonaudio(nonaudio), .orig(orig),
        .blk_dir_out(blk_dir_out), .blk_sync_in(blk_sync_in),
        .blk_start_out(blk_start_out), .tx_p(tx_p), .tx_n(tx_n)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] aud_of(int n);
        return 24'(n * 32'h00A4B7) ^ 24'h800001;
    endfunction

    function automatic bit cs_of(int i, bit na, bit cp, bit en, bit og);
        case (i)
            1: return na;
            2: return cp;
            3: return !en;
            15: return og;
            default: return 1'b0;
        endcase
    endfunction

    // Start one subframe at the current falling edge and capture its 64 cycles.
    task automatic tx_sub(bit left, logic [23:0] a, bit v, bit u, bit c);
        lrck = left; audio_in = a; v_in = v; u_in = u; c_copy = c;
        for (int j = 1; j <= 64; j++) begin
            blk_sync_in = (j >= 10 && j < 10 + force_len);
            @(negedge clk);
            cap[ncap] = tx_p;
            sob[ncap] = blk_start_out;
            if (tx_n !== ~tx_p) compl_err = 1;
            ncap++;
        end
        blk_sync_in = 0;
        force_len = 0;
    endtask

    task automatic flush();
        repeat (2) begin
            @(negedge clk);
            cap[ncap] = tx_p;
            sob[ncap] = blk_start_out;
            ncap++;
        end
    endtask

    // Decode subframe n of the captured stream: 0 left, 1 right, 2 block, 3 bad.
    task automatic dec(int n, output int pt, output logic [31:0] bits, output bit ok);
        int i0;
        logic [7:0] p;
        i0 = 64 * n + 1;
        for (int k = 0; k < 8; k++) p[7-k] = cap[i0+k] ^ cap[i0-1];
        pt = (p == 8'b11100010) ? 0 : (p == 8'b11100100) ? 1 : (p == 8'b11101000) ? 2 : 3;
        ok = 1;
        bits = '0;
        for (int s = 4; s < 32; s++) begin
            if (cap[i0+2*s] == cap[i0+2*s-1]) ok = 0;
            bits[s] = cap[i0+2*s] ^ cap[i0+2*s+1];
        end
    endtask

    task automatic test_reset();
        rst_n = 0;
        for (int k = 0; k < 6; k++) begin
            lrck = k[0];
            @(negedge clk);
            chk(tx_p == 0 && tx_n == 0 && blk_start_out == 0, "R1", "outputs in reset",
                {tx_p, tx_n, blk_start_out}, 0);
        end
        lrck = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    // Two full blocks in static mode with the strobe as an output.
    task automatic test_blocks();
        int pt, e_pre, e_aud, e_vu, e_par, e_code, e_cs1, e_cs2, e_sob, emph2;
        logic [31:0] b;
        bit ok, zall, zany, left, na, cp, en, og;
        int f;
        cs_mode_b = 0; blk_dir_out = 1;
        nonaudio = 1; c_copy = 0; emph_n = 0; orig = 1;
        ncap = 0; compl_err = 0;
        for (int fr = 0; fr < 384; fr++) begin
            if (fr == 192) begin nonaudio = 0; emph_n = 1; orig = 0; end
            cp = (fr < 192) ? 1'b0 : 1'b1;
            tx_sub(1, aud_of(2*fr), (2*fr)%2 ^ ((2*fr)>>2)%2, ((2*fr)>>1)%2 ^ ((2*fr)>>3)%2, cp);
            tx_sub(0, aud_of(2*fr+1), (2*fr+1)%2 ^ ((2*fr+1)>>2)%2, ((2*fr+1)>>1)%2 ^ ((2*fr+1)>>3)%2, cp);
        end
        flush();
        e_pre = 0; e_aud = 0; e_vu = 0; e_par = 0; e_code = 0; e_cs1 = 0; e_cs2 = 0; e_sob = 0; emph2 = 0;
        for (int n = 0; n < 768; n++) begin
            dec(n, pt, b, ok);
            f = n / 2;
            left = (n % 2 == 0);
            if (pt != (left ? ((f % 192 == 0) ? 2 : 0) : 1)) e_pre++;
            if (b[27:4] != aud_of(n)) e_aud++;
            if (b[28] != (n%2 ^ (n>>2)%2) || b[29] != ((n>>1)%2 ^ (n>>3)%2)) e_vu++;
            if (^b != 1'b0) e_par++;
            if (!ok) e_code++;
            na = (f < 192); cp = (f >= 192); en = (f >= 192); og = (f < 192);
            if (f < 192 && b[30] != cs_of(f % 192, na, cp, en, og)) e_cs1++;
            if (f >= 192 && b[30] != cs_of(f % 192, na, cp, en, og)) e_cs2++;
            if (f >= 192 && (f % 192) >= 3 && (f % 192) <= 5 && b[30]) emph2++;
            zall = 1; zany = 0;
            for (int k = 0; k < 64; k++) begin
                zall &= sob[64*n+k];
                zany |= sob[64*n+k];
            end
            if ((left && f % 192 == 0) ? !zall : zany) e_sob++;
        end
        chk(e_code == 0, "R2", "cell boundary errors", e_code, 0);
        chk(!compl_err, "R2", "tx_n not complement", compl_err, 0);
        chk(e_aud == 0, "R3", "audio slot mismatches", e_aud, 0);
        chk(e_par == 0, "R3", "parity errors", e_par, 0);
        chk(e_pre == 0, "R4", "preamble mismatches", e_pre, 0);
        chk(e_vu == 0, "R5", "V/U mismatches", e_vu, 0);
        dec(384, pt, b, ok);
        chk(pt == 2, "R6", "frame 192 left preamble", pt, 2);
        dec(382, pt, b, ok);
        chk(pt == 0, "R6", "frame 191 left preamble", pt, 0);
        chk(e_sob == 0, "R7", "strobe output mismatches", e_sob, 0);
        chk(e_cs1 == 0, "R9", "status bits block 1", e_cs1, 0);
        chk(e_cs2 == 0, "R11", "status bits block 2", e_cs2, 0);
        chk(emph2 == 0, "R11", "emphasis field not 000", emph2, 0);
    endtask

    // Serial C-bit mode: C slot follows the pin per subframe.
    task automatic test_serial_c();
        int pt, e_c;
        logic [31:0] b;
        bit ok;
        cs_mode_b = 1;
        ncap = 0;
        for (int n = 0; n < 8; n++)
            tx_sub(n % 2 == 0, aud_of(n + 5), n % 2, (n / 2) % 2, (n % 3) == 0);
        flush();
        e_c = 0;
        for (int n = 0; n < 8; n++) begin
            dec(n, pt, b, ok);
            if (b[30] != ((n % 3) == 0)) e_c++;
            if (b[28] != n % 2 || b[29] != (n / 2) % 2) e_c++;
        end
        chk(e_c == 0, "R10", "serial C / V / U mismatches", e_c, 0);
        cs_mode_b = 0;
    endtask

    // Strobe as an input: a 2-clock pulse is ignored, a 3-clock pulse forces a block.
    task automatic test_force();
        int pt, zout;
        logic [31:0] b;
        bit ok;
        blk_dir_out = 0;
        ncap = 0;
        for (int fr = 0; fr < 8; fr++) begin
            if (fr == 1) force_len = 2;
            if (fr == 4) force_len = 3;
            tx_sub(1, aud_of(fr), 0, 0, 0);
            tx_sub(0, aud_of(fr), 0, 0, 0);
        end
        flush();
        dec(4, pt, b, ok);
        chk(pt == 0, "R8", "2-clock pulse forced block", pt, 0);
        dec(10, pt, b, ok);
        chk(pt == 2, "R8", "3-clock pulse next left preamble", pt, 2);
        dec(12, pt, b, ok);
        chk(pt == 0, "R8", "frame after forced start", pt, 0);
        zout = 0;
        for (int k = 0; k < ncap; k++) zout += sob[k];
        chk(zout == 0, "R7", "strobe high in input direction", zout, 0);
        blk_dir_out = 1;
    endtask

    // Reset while transmitting drives the line low at the next edge.
    task automatic test_mid_reset();
        lrck = 1;
        repeat (20) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk(tx_p == 0 && tx_n == 0 && blk_start_out == 0, "R1", "outputs after mid-run reset",
            {tx_p, tx_n, blk_start_out}, 0);
        rst_n = 1;
    endtask

    initial begin
        test_reset();
        test_blocks();
        test_serial_c();
        test_force();
        test_mid_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule